// File: doc/BRIEF.md
# Serial Receiver Reset Sequencer

This block brings a high-speed serial receiver channel out of reset after power-up, for a channel whose clock recovery locks on its own. It runs on the recovered parallel clock. It holds two reset outputs, one for the analog front end and one for the digital data path, and it releases them in order. First it waits for the calibration controller to stop reporting busy. Then it waits a fixed two-cycle guard and releases the analog reset. Then it waits for frequency lock and a further settle interval before it releases the digital reset and raises ready.

The busy and lock inputs come from other timing domains, so each passes through a two-flop synchroniser first. The busy synchroniser resets to the busy value, so the sequencer never takes a reset-time zero for a finished calibration. Calibration busy appears only at first power-up, and a later sequence sees busy only while a reconfiguration access is running. The sequencer therefore goes ahead as soon as busy reads low and never waits for a busy pulse. If lock drops once the analog reset is released, the sequencer falls back to waiting for lock and reasserts the digital reset only.

Top module: `rx_reset_seq`

## Requirements
- R1: While the synchronised busy flag is high before the analog release, the step output reads 0 (calibration wait) and both reset outputs are high.
- R2: Once busy reads low, the step output reads 1 (guard) for exactly GUARD_CYCLES cycles. Then the analog reset falls and the step output reads 2 (lock wait). Counted from the cycle where the busy input changes, the analog reset falls after GUARD_CYCLES+3 rising edges.
- R3: The digital reset never falls while the analog reset is high, and it stays high in the lock-wait step while lock is low.
- R4: With lock held high, the step output reads 3 (settle) for SETTLE_CYCLES cycles and then reads 4 (ready), and the digital reset falls. Counted from the lock input change, this takes SETTLE_CYCLES+3 rising edges.
- R5: The ready output is high exactly when both reset outputs are low.
- R6: If lock drops during settle, the block returns to lock wait. The next settle interval starts again from zero.
- R7: If lock drops in the ready step, the digital reset rises again and the step returns to 2. The analog reset stays low.
- R8: Driving por_n low forces step 0, both resets high and ready low at once, without a clock edge.
- R9: If busy rises again during the guard step, the block returns to step 0. The guard count starts again from zero at the next busy low.
- R10: After por_n is released with busy already low, the analog reset falls without any busy pulse, GUARD_CYCLES+5 edges after the release.
- R11: A lock change reaches the sequence only through two synchroniser flops, so outputs do not react to it within two rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-domain clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| cal_busy_i | input | 1 | Calibration or reconfiguration busy flag (asynchronous) |
| freq_lock_i | input | 1 | Clock-recovery frequency lock (asynchronous) |
| ana_rst_o | output | 1 | Analog receiver reset, active high |
| dig_rst_o | output | 1 | Digital receiver reset, active high |
| rx_ready_o | output | 1 | Receiver ready for data |
| seq_state_o | output | 3 | Current step: 0 cal wait, 1 guard, 2 lock wait, 3 settle, 4 ready |

## Verification
The bench builds the block with GUARD_CYCLES at its required value of 2 and SETTLE_CYCLES reduced to 5. With these values every settle interval ends within a few cycles. The bench can then land a lock drop in the middle of settle and show that the next interval restarts from zero. It can also sample the exact edge of each release. The synchroniser depth stays at 2, so the bench counts the input-to-output latencies exactly and checks them at the edge where each output changes.

// File: rtl/rxrs_pkg.sv
package rxrs_pkg;
  typedef enum logic [2:0] {
    RS_CAL      = 3'd0,
    RS_GUARD    = 3'd1,
    RS_LOCKWAIT = 3'd2,
    RS_SETTLE   = 3'd3,
    RS_READY    = 3'd4
  } rxrs_state_e;
endpackage

// File: rtl/rxrs_rst_sync.sv
// Asynchronous assert, synchronous release of the block reset.
module rxrs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/rxrs_bit_sync.sv
// Multi-bit flop-chain synchroniser with a per-bit reset value.
module rxrs_bit_sync #(
  parameter int               WIDTH   = 2,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= {STAGES{RST_VAL[b]}};
      else        ff_q <= {ff_q[STAGES-2:0], d[b]};
    end
    assign q[b] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/rxrs_counter.sv
// Shared interval counter with clear priority over enable.
module rxrs_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [WIDTH-1:0] cnt
);
  logic [WIDTH-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clr || en) cnt <= cnt_d;
  end
endmodule

// File: rtl/rxrs_fsm.sv
module rxrs_fsm
  import rxrs_pkg::*;
#(
  parameter int GUARD_CYCLES  = 2,
  parameter int SETTLE_CYCLES = 16,
  parameter int CNT_W         = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_s,
  input  logic             lock_s,
  input  logic [CNT_W-1:0] cnt,
  output logic             cnt_clr,
  output logic             cnt_en,
  output rxrs_state_e      state,
  output logic             ana_rst,
  output logic             dig_rst,
  output logic             ready
);
  localparam logic [CNT_W-1:0] GUARD_LAST  = CNT_W'(GUARD_CYCLES - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);

  rxrs_state_e state_d;

  always_comb begin
    state_d = state;
    cnt_clr = 1'b0;
    cnt_en  = 1'b0;
    unique case (state)
      RS_CAL: begin
        if (!busy_s) begin
          state_d = RS_GUARD;
          cnt_clr = 1'b1;
        end
      end
      RS_GUARD: begin
        if (busy_s) begin
          state_d = RS_CAL;
          cnt_clr = 1'b1;
        end else if (cnt == GUARD_LAST) begin
          state_d = RS_LOCKWAIT;
        end else begin
          cnt_en = 1'b1;
        end
      end
      RS_LOCKWAIT: begin
        if (lock_s) begin
          state_d = RS_SETTLE;
          cnt_clr = 1'b1;
        end
      end
      RS_SETTLE: begin
        if (!lock_s) begin
          state_d = RS_LOCKWAIT;
          cnt_clr = 1'b1;
        end else if (cnt == SETTLE_LAST) begin
          state_d = RS_READY;
        end else begin
          cnt_en = 1'b1;
        end
      end
      RS_READY: begin
        if (!lock_s) state_d = RS_LOCKWAIT;
      end
      default: state_d = RS_CAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= RS_CAL;
    else        state <= state_d;
  end

  assign ana_rst = (state == RS_CAL) || (state == RS_GUARD);
  assign dig_rst = (state != RS_READY);
  assign ready   = !ana_rst && !dig_rst;
endmodule

// File: rtl/rx_reset_seq.sv
module rx_reset_seq
  import rxrs_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int GUARD_CYCLES  = 2,
  parameter int SETTLE_CYCLES = 1024
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       cal_busy_i,
  input  logic       freq_lock_i,
  output logic       ana_rst_o,
  output logic       dig_rst_o,
  output logic       rx_ready_o,
  output logic [2:0] seq_state_o
);
  localparam int MAX_CNT = (GUARD_CYCLES > SETTLE_CYCLES) ? GUARD_CYCLES : SETTLE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic             rst_n;
  logic [1:0]       sync_q;
  logic             cnt_clr;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt;
  rxrs_state_e      state;

  rxrs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .arst_n  (por_n),
    .rst_n_o (rst_n)
  );

  // Bit 1 busy resets to 1 so reset time never looks like finished calibration.
  rxrs_bit_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_in_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cal_busy_i, freq_lock_i}),
    .q     (sync_q)
  );

  rxrs_counter #(.WIDTH(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .en    (cnt_en),
    .cnt   (cnt)
  );

  rxrs_fsm #(
    .GUARD_CYCLES  (GUARD_CYCLES),
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .CNT_W         (CNT_W)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy_s  (sync_q[1]),
    .lock_s  (sync_q[0]),
    .cnt     (cnt),
    .cnt_clr (cnt_clr),
    .cnt_en  (cnt_en),
    .state   (state),
    .ana_rst (ana_rst_o),
    .dig_rst (dig_rst_o),
    .ready   (rx_ready_o)
  );

  assign seq_state_o = state;
endmodule

// File: rtl/rx_reset_seq_chk.sv
module rx_reset_seq_chk
  import rxrs_pkg::*;
(
  input logic       clk,
  input logic       por_n,
  input logic       ana_rst,
  input logic       dig_rst,
  input logic       ready,
  input logic [2:0] state
);
  p_dig_covers_ana_r3: assert property (@(posedge clk) disable iff (!por_n)
    ana_rst |-> dig_rst);

  p_guard_before_release_r2: assert property (@(posedge clk) disable iff (!por_n)
    $fell(ana_rst) |-> ($past(state) == RS_GUARD) && ($past(state, 2) == RS_GUARD));

  p_analog_stays_low_r7: assert property (@(posedge clk) disable iff (!por_n)
    !ana_rst |=> !ana_rst);

  p_ready_from_settle_r4: assert property (@(posedge clk) disable iff (!por_n)
    $rose(ready) |-> ($past(state) == RS_SETTLE));

  p_ready_both_low_r5: assert property (@(posedge clk) disable iff (!por_n)
    ready |-> (!ana_rst && !dig_rst));

  p_settle_needs_lockwait_r6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(state == RS_SETTLE) |-> ($past(state) == RS_LOCKWAIT));
endmodule

bind rx_reset_seq rx_reset_seq_chk u_chk (
  .clk     (clk),
  .por_n   (por_n),
  .ana_rst (ana_rst_o),
  .dig_rst (dig_rst_o),
  .ready   (rx_ready_o),
  .state   (seq_state_o)
);

// File: tb/rx_reset_seq_tb.sv
module rx_reset_seq_tb;
  localparam int NVEC = 13;

  logic       clk = 1'b0;
  logic       por_n;
  logic       busy;
  logic       lock;
  logic       ana, dig, rdy;
  logic [2:0] st;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rx_reset_seq #(.SYNC_STAGES(2), .GUARD_CYCLES(2), .SETTLE_CYCLES(5)) u_dut (
    .clk         (clk),
    .por_n       (por_n),
    .cal_busy_i  (busy),
    .freq_lock_i (lock),
    .ana_rst_o   (ana),
    .dig_rst_o   (dig),
    .rx_ready_o  (rdy),
    .seq_state_o (st)
  );

  // {req[3:0], busy, lock, edges[7:0], state[2:0], ana, dig, rdy}
  localparam logic [19:0] VEC [NVEC] = '{
    {4'd1,  1'b1, 1'b0, 8'd4, 3'd0, 1'b1, 1'b1, 1'b0}, // R1 held in cal wait
    {4'd2,  1'b0, 1'b0, 8'd4, 3'd1, 1'b1, 1'b1, 1'b0}, // R2 still guarding
    {4'd2,  1'b0, 1'b0, 8'd1, 3'd2, 1'b0, 1'b1, 1'b0}, // R2 analog release edge
    {4'd3,  1'b0, 1'b0, 8'd6, 3'd2, 1'b0, 1'b1, 1'b0}, // R3 waits for lock
    {4'd4,  1'b0, 1'b1, 8'd3, 3'd3, 1'b0, 1'b1, 1'b0}, // R4 settle entered
    {4'd4,  1'b0, 1'b1, 8'd4, 3'd3, 1'b0, 1'b1, 1'b0}, // R4 minimum not reached
    {4'd5,  1'b0, 1'b1, 8'd1, 3'd4, 1'b0, 1'b0, 1'b1}, // R5 ready
    {4'd11, 1'b0, 1'b0, 8'd2, 3'd4, 1'b0, 1'b0, 1'b1}, // R11 sync latency
    {4'd7,  1'b0, 1'b0, 8'd1, 3'd2, 1'b0, 1'b1, 1'b0}, // R7 lock lost
    {4'd6,  1'b0, 1'b1, 8'd5, 3'd3, 1'b0, 1'b1, 1'b0}, // R6 partial settle
    {4'd6,  1'b0, 1'b0, 8'd3, 3'd2, 1'b0, 1'b1, 1'b0}, // R6 drop mid settle
    {4'd6,  1'b0, 1'b1, 8'd7, 3'd3, 1'b0, 1'b1, 1'b0}, // R6 count restarted
    {4'd4,  1'b0, 1'b1, 8'd1, 3'd4, 1'b0, 1'b0, 1'b1}  // R4 full interval
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input int req, input logic [2:0] es,
                     input logic ea, input logic ed, input logic er);
    checks++;
    if ({st, ana, dig, rdy} !== {es, ea, ed, er}) begin
      fails++;
      $display("FAIL R%0d: state/ana/dig/rdy actual %0d/%b/%b/%b expected %0d/%b/%b/%b",
               req, st, ana, dig, rdy, es, ea, ed, er);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    por_n = 1'b0;
    busy  = 1'b1;
    lock  = 1'b0;
    step(3);
    chk(8, 3'd0, 1'b1, 1'b1, 1'b0);          // R8 reset state
    por_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      busy = VEC[i][15];
      lock = VEC[i][14];
      step(int'(VEC[i][13:6]));
      chk(int'(VEC[i][19:16]), VEC[i][5:3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R8: asynchronous entry, no clock edge
    por_n = 1'b0;
    #1;
    chk(8, 3'd0, 1'b1, 1'b1, 1'b0);

    // R10: no busy pulse after a later reset
    busy = 1'b0;
    lock = 1'b0;
    step(2);
    por_n = 1'b1;
    step(6);
    chk(10, 3'd1, 1'b1, 1'b1, 1'b0);
    step(1);
    chk(10, 3'd2, 1'b0, 1'b1, 1'b0);

    // R9: busy returns during guard
    por_n = 1'b0;
    busy  = 1'b1;
    step(2);
    por_n = 1'b1;
    step(4);
    chk(1, 3'd0, 1'b1, 1'b1, 1'b0);          // R1
    busy = 1'b0;
    step(1);
    busy = 1'b1;
    step(3);
    chk(9, 3'd0, 1'b1, 1'b1, 1'b0);
    busy = 1'b0;
    step(4);
    chk(9, 3'd1, 1'b1, 1'b1, 1'b0);
    step(1);
    chk(9, 3'd2, 1'b0, 1'b1, 1'b0);

    done = 1'b1;
    report();
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end
endmodule